// File: doc/BRIEF.md
# Bridge Interrupt Aggregator

This block gathers event and error indications from a memory-bus-to-PCIe bridge into status registers, qualifies each with a mask, and drives one level-sensitive interrupt line. Sources arrive as one-cycle pulses on four event buses and set sticky status bits. Software reads and writes the registers through a simple single-cycle register port to find out why the line is high and to clear the cause.

There are five status groups. The local and host groups use enable-high masks: a mask bit of 1 lets its source through. The link-event group and the two RAM error groups use suppress-high masks: a mask bit of 1 blocks its source. The link-event word keeps its three status bits and its three mask bits in one register. Each RAM error class (single-bit, double-bit) also has a saturating event counter.

Register map (word address on `regAddr`): 0 local status, 1 local mask, 2 host status, 3 host mask, 4 link word, 5 single-bit status, 6 single-bit mask, 7 double-bit status, 8 double-bit mask, 9 single-bit counter, 10 double-bit counter. All other addresses read zero and ignore writes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status register and both counters read 0, the local and host masks read 0, the link mask field [18:16] reads 3'b111, both RAM masks read 16'hFFFF, and `irq` is low.
- R2: A pulse on `locEvt` sets local status bits 8, 9, 16–18, 20–22 and 24–31 only; pulses on the other local positions leave them reading 0.
- R3: A pending local status bit drives `irq` high only while its local mask bit (address 1) is 1.
- R4: Writing a word to a status address (0, 2, 5, 7, or bits [2:0] of address 4) clears every status bit where that word has a 1 and leaves the others unchanged; writing all ones clears the whole register.
- R5: The host pair (addresses 2 and 3) covers all 32 bits and follows the enable-high and write-one-to-clear rules of the local pair.
- R6: The link word holds L2-exit, hot-reset-exit and link-up-exit status in bits [2:0] and their masks in bits [18:16]; a mask bit of 1 suppresses its event, and a single write both clears status bits and loads the mask field.
- R7: The single-bit and double-bit RAM error status registers are 16 bits wide (four 4-bit groups each), set by `sbeEvt`/`dbeEvt`, and a mask bit of 1 keeps its bit off `irq`.
- R8: Each RAM error counter increments by one in every cycle in which any bit of its class pulses (regardless of masks), saturates at its maximum, is cleared by a write of 0, and ignores a write of any other value; a clear in the same cycle as a pulse leaves 0.
- R9: `irq` is the OR of every enabled pending bit in all five groups, stays high while any such bit is pending, and drops in the cycle after the last one is cleared or masked.
- R10: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit remains set.
- R11: Reads of addresses 11 to 15 return 0, and a write reaches at most one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| locEvt | input | 32 | Local event pulses |
| hostEvt | input | 32 | Host event pulses |
| linkEvt | input | 3 | Link event pulses (L2 exit, hot-reset exit, link-up exit) |
| sbeEvt | input | RAM_W | Single-bit RAM error pulses |
| dbeEvt | input | RAM_W | Double-bit RAM error pulses |
| irq | output | 1 | Level interrupt |

## Verification
A status bit stuck, lost or set in the wrong position shows at the register port on the very next read, one cycle after the pulse, and a polarity mistake in any group's mask shows as `irq` being high or low the wrong way in the same cycle the status register is read. Because the groups mix enable-high and suppress-high masks, each group is driven with its mask both open and closed, and `irq` is compared alongside every readback. Races between a clearing write and a new pulse, counter saturation and the split status/mask link word are exercised directly, since those are where wrong internal state would otherwise stay hidden until a later event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int REG_W = 32;

  // register word addresses
  localparam logic [3:0] A_LOC_STAT  = 4'd0;
  localparam logic [3:0] A_LOC_MASK  = 4'd1;
  localparam logic [3:0] A_HOST_STAT = 4'd2;
  localparam logic [3:0] A_HOST_MASK = 4'd3;
  localparam logic [3:0] A_LINK      = 4'd4;
  localparam logic [3:0] A_SBE_STAT  = 4'd5;
  localparam logic [3:0] A_SBE_MASK  = 4'd6;
  localparam logic [3:0] A_DBE_STAT  = 4'd7;
  localparam logic [3:0] A_DBE_MASK  = 4'd8;
  localparam logic [3:0] A_SBE_CNT   = 4'd9;
  localparam logic [3:0] A_DBE_CNT   = 4'd10;

  // implemented local status positions
  localparam logic [REG_W-1:0] LOC_IMPL = 32'hFF77_0300;

  localparam int LINK_W        = 3;
  localparam int LINK_MASK_LSB = 16;

  typedef struct packed {
    logic wrLocStat;
    logic wrLocMask;
    logic wrHostStat;
    logic wrHostMask;
    logic wrLink;
    logic wrSbeStat;
    logic wrSbeMask;
    logic wrDbeStat;
    logic wrDbeMask;
    logic clrSbeCnt;
    logic clrDbeCnt;
    logic [REG_W-1:0] wdata;
  } ctlStrobe_t;

  typedef struct packed {
    logic [REG_W-1:0] locStat;
    logic [REG_W-1:0] locMask;
    logic [REG_W-1:0] hostStat;
    logic [REG_W-1:0] hostMask;
    logic [REG_W-1:0] linkWord;
    logic [REG_W-1:0] sbeStat;
    logic [REG_W-1:0] sbeMask;
    logic [REG_W-1:0] dbeStat;
    logic [REG_W-1:0] dbeMask;
    logic [REG_W-1:0] sbeCnt;
    logic [REG_W-1:0] dbeCnt;
  } regView_t;

endpackage

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int          W           = 32,
  parameter logic [W-1:0] IMPL       = '1,
  parameter bit          ENABLE_HIGH = 1'b1,
  parameter logic [W-1:0] MASK_RST   = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] evt,
  input  logic         wrStat,
  input  logic [W-1:0] clrBits,
  input  logic         wrMask,
  input  logic [W-1:0] maskIn,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic         pend
);

  logic [W-1:0] keepBits;
  logic [W-1:0] enabled;

  assign keepBits = wrStat ? (stat & ~clrBits) : stat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat <= '0;
      mask <= MASK_RST & IMPL;
    end else begin
      stat <= (keepBits | evt) & IMPL;
      if (wrMask) mask <= maskIn & IMPL;
    end
  end

  generate
    if (ENABLE_HIGH) begin : g_en_high
      assign enabled = stat & mask;
    end else begin : g_sup_high
      assign enabled = stat & ~mask;
    end
  endgenerate

  assign pend = |enabled;

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|(evt & IMPL)) |=> ((stat & $past(evt & IMPL)) == $past(evt & IMPL)));

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && ((clrBits & evt) == '0)) |=> ((stat & $past(clrBits)) == '0));

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && |(clrBits & evt & IMPL))
      |=> ((stat & $past(clrBits & evt & IMPL)) == $past(clrBits & evt & IMPL)));

endmodule

// File: rtl/irq_agg_cnt.sv
module irq_agg_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hit,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN)                     cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (hit && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  a_r8_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0));

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  regView_t          view,
  output ctlStrobe_t        strobe,
  output logic [REG_W-1:0]  regRdata
);

  logic [3:0] addrLo;
  logic       addrHit;

  generate
    if (ADDR_W > 4) begin : g_wide
      assign addrHit = (regAddr[ADDR_W-1:4] == '0);
      assign addrLo  = regAddr[3:0];
    end else begin : g_narrow
      assign addrHit = 1'b1;
      assign addrLo  = 4'(regAddr);
    end
  endgenerate

  logic we;
  assign we = regWe && addrHit;

  always_comb begin
    strobe            = '0;
    strobe.wdata      = regWdata;
    strobe.wrLocStat  = we && addrLo == A_LOC_STAT;
    strobe.wrLocMask  = we && addrLo == A_LOC_MASK;
    strobe.wrHostStat = we && addrLo == A_HOST_STAT;
    strobe.wrHostMask = we && addrLo == A_HOST_MASK;
    strobe.wrLink     = we && addrLo == A_LINK;
    strobe.wrSbeStat  = we && addrLo == A_SBE_STAT;
    strobe.wrSbeMask  = we && addrLo == A_SBE_MASK;
    strobe.wrDbeStat  = we && addrLo == A_DBE_STAT;
    strobe.wrDbeMask  = we && addrLo == A_DBE_MASK;
    strobe.clrSbeCnt  = we && addrLo == A_SBE_CNT && regWdata == '0;
    strobe.clrDbeCnt  = we && addrLo == A_DBE_CNT && regWdata == '0;
  end

  always_comb begin
    regRdata = '0;
    if (addrHit) begin
      case (addrLo)
        A_LOC_STAT:  regRdata = view.locStat;
        A_LOC_MASK:  regRdata = view.locMask;
        A_HOST_STAT: regRdata = view.hostStat;
        A_HOST_MASK: regRdata = view.hostMask;
        A_LINK:      regRdata = view.linkWord;
        A_SBE_STAT:  regRdata = view.sbeStat;
        A_SBE_MASK:  regRdata = view.sbeMask;
        A_DBE_STAT:  regRdata = view.dbeStat;
        A_DBE_MASK:  regRdata = view.dbeMask;
        A_SBE_CNT:   regRdata = view.sbeCnt;
        A_DBE_CNT:   regRdata = view.dbeCnt;
        default:     regRdata = '0;
      endcase
    end
  end

  a_r11_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrLocStat, strobe.wrLocMask, strobe.wrHostStat, strobe.wrHostMask,
              strobe.wrLink, strobe.wrSbeStat, strobe.wrSbeMask, strobe.wrDbeStat,
              strobe.wrDbeMask, strobe.clrSbeCnt, strobe.clrDbeCnt}));

endmodule

// File: rtl/irq_agg_dpath.sv
module irq_agg_dpath
  import irq_agg_pkg::*;
#(
  parameter int RAM_W = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [REG_W-1:0]  locEvt,
  input  logic [REG_W-1:0]  hostEvt,
  input  logic [LINK_W-1:0] linkEvt,
  input  logic [RAM_W-1:0]  sbeEvt,
  input  logic [RAM_W-1:0]  dbeEvt,
  output regView_t          view,
  output logic              irq
);

  logic [REG_W-1:0]  locS, locM, hostS, hostM;
  logic [LINK_W-1:0] linkS, linkM;
  logic [RAM_W-1:0]  sbeS, sbeM, dbeS, dbeM;
  logic [CNT_W-1:0]  sbeC, dbeC;
  logic pLoc, pHost, pLink, pSbe, pDbe;

  irq_agg_bank #(.W(REG_W), .IMPL(LOC_IMPL), .ENABLE_HIGH(1'b1), .MASK_RST('0)) u_loc (
    .clk, .rstN, .evt(locEvt),
    .wrStat(strobe.wrLocStat), .clrBits(strobe.wdata),
    .wrMask(strobe.wrLocMask), .maskIn(strobe.wdata),
    .stat(locS), .mask(locM), .pend(pLoc));

  irq_agg_bank #(.W(REG_W), .IMPL('1), .ENABLE_HIGH(1'b1), .MASK_RST('0)) u_host (
    .clk, .rstN, .evt(hostEvt),
    .wrStat(strobe.wrHostStat), .clrBits(strobe.wdata),
    .wrMask(strobe.wrHostMask), .maskIn(strobe.wdata),
    .stat(hostS), .mask(hostM), .pend(pHost));

  irq_agg_bank #(.W(LINK_W), .IMPL('1), .ENABLE_HIGH(1'b0), .MASK_RST('1)) u_link (
    .clk, .rstN, .evt(linkEvt),
    .wrStat(strobe.wrLink), .clrBits(strobe.wdata[LINK_W-1:0]),
    .wrMask(strobe.wrLink), .maskIn(strobe.wdata[LINK_MASK_LSB +: LINK_W]),
    .stat(linkS), .mask(linkM), .pend(pLink));

  irq_agg_bank #(.W(RAM_W), .IMPL('1), .ENABLE_HIGH(1'b0), .MASK_RST('1)) u_sbe (
    .clk, .rstN, .evt(sbeEvt),
    .wrStat(strobe.wrSbeStat), .clrBits(strobe.wdata[RAM_W-1:0]),
    .wrMask(strobe.wrSbeMask), .maskIn(strobe.wdata[RAM_W-1:0]),
    .stat(sbeS), .mask(sbeM), .pend(pSbe));

  irq_agg_bank #(.W(RAM_W), .IMPL('1), .ENABLE_HIGH(1'b0), .MASK_RST('1)) u_dbe (
    .clk, .rstN, .evt(dbeEvt),
    .wrStat(strobe.wrDbeStat), .clrBits(strobe.wdata[RAM_W-1:0]),
    .wrMask(strobe.wrDbeMask), .maskIn(strobe.wdata[RAM_W-1:0]),
    .stat(dbeS), .mask(dbeM), .pend(pDbe));

  irq_agg_cnt #(.CNT_W(CNT_W)) u_sbeCnt (
    .clk, .rstN, .hit(|sbeEvt), .clr(strobe.clrSbeCnt), .cnt(sbeC));

  irq_agg_cnt #(.CNT_W(CNT_W)) u_dbeCnt (
    .clk, .rstN, .hit(|dbeEvt), .clr(strobe.clrDbeCnt), .cnt(dbeC));

  always_comb begin
    view          = '0;
    view.locStat  = locS;
    view.locMask  = locM;
    view.hostStat = hostS;
    view.hostMask = hostM;
    view.linkWord[LINK_W-1:0]                 = linkS;
    view.linkWord[LINK_MASK_LSB +: LINK_W]    = linkM;
    view.sbeStat[RAM_W-1:0] = sbeS;
    view.sbeMask[RAM_W-1:0] = sbeM;
    view.dbeStat[RAM_W-1:0] = dbeS;
    view.dbeMask[RAM_W-1:0] = dbeM;
    view.sbeCnt[CNT_W-1:0]  = sbeC;
    view.dbeCnt[CNT_W-1:0]  = dbeC;
  end

  assign irq = pLoc | pHost | pLink | pSbe | pDbe;

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (locS == '0 && hostS == '0 && linkS == '0 && sbeS == '0 && dbeS == '0) |-> !irq);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RAM_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [31:0]       locEvt,
  input  logic [31:0]       hostEvt,
  input  logic [2:0]        linkEvt,
  input  logic [RAM_W-1:0]  sbeEvt,
  input  logic [RAM_W-1:0]  dbeEvt,
  output logic              irq
);

  ctlStrobe_t strobe;
  regView_t   view;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWdata,
    .view, .strobe, .regRdata);

  irq_agg_dpath #(.RAM_W(RAM_W), .CNT_W(CNT_W)) u_dpath (
    .clk, .rstN, .strobe, .locEvt, .hostEvt, .linkEvt,
    .sbeEvt, .dbeEvt, .view, .irq);

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] locEvt = '0;
  logic [31:0] hostEvt = '0;
  logic [2:0]  linkEvt = '0;
  logic [15:0] sbeEvt = '0;
  logic [15:0] dbeEvt = '0;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  irq_aggregator #(.ADDR_W(4), .RAM_W(16), .CNT_W(4)) i_irq_aggregator (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata,
    .locEvt, .hostEvt, .linkEvt, .sbeEvt, .dbeEvt, .irq);

  localparam logic [1:0] K_WR = 2'd0, K_EV = 2'd1, K_RD = 2'd2;
  localparam int NV = 51;
  // {kind, addr/source, data, expected read, expected irq, requirement}
  localparam logic [74:0] VEC [NV] = '{
    {K_RD, 4'd0,  32'h0, 32'h0000_0000, 1'b0, 4'd1},  // R1
    {K_RD, 4'd1,  32'h0, 32'h0000_0000, 1'b0, 4'd1},  // R1
    {K_RD, 4'd4,  32'h0, 32'h0007_0000, 1'b0, 4'd1},  // R1
    {K_RD, 4'd6,  32'h0, 32'h0000_FFFF, 1'b0, 4'd1},  // R1
    {K_RD, 4'd8,  32'h0, 32'h0000_FFFF, 1'b0, 4'd1},  // R1
    {K_EV, 4'd0,  32'hFFFF_FFFF, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd0,  32'h0, 32'hFF77_0300, 1'b0, 4'd2},  // R2
    {K_WR, 4'd1,  32'h1000_0000, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd0,  32'h0, 32'hFF77_0300, 1'b1, 4'd3},  // R3
    {K_RD, 4'd1,  32'h0, 32'h1000_0000, 1'b1, 4'd3},  // R3
    {K_WR, 4'd0,  32'h1000_0000, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd0,  32'h0, 32'hEF77_0300, 1'b0, 4'd4},  // R4
    {K_WR, 4'd0,  32'hFFFF_FFFF, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd0,  32'h0, 32'h0000_0000, 1'b0, 4'd4},  // R4
    {K_WR, 4'd1,  32'h0, 32'h0, 1'b0, 4'd0},
    {K_EV, 4'd1,  32'h0000_0001, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd2,  32'h0, 32'h0000_0001, 1'b0, 4'd5},  // R5
    {K_WR, 4'd3,  32'h0000_0001, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd2,  32'h0, 32'h0000_0001, 1'b1, 4'd5},  // R5
    {K_WR, 4'd2,  32'h0000_0001, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd2,  32'h0, 32'h0000_0000, 1'b0, 4'd5},  // R5
    {K_EV, 4'd2,  32'h0000_0005, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd4,  32'h0, 32'h0007_0005, 1'b0, 4'd6},  // R6
    {K_WR, 4'd4,  32'h0003_0001, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd4,  32'h0, 32'h0003_0004, 1'b1, 4'd6},  // R6
    {K_WR, 4'd4,  32'h0007_0000, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd4,  32'h0, 32'h0007_0004, 1'b0, 4'd6},  // R6
    {K_WR, 4'd4,  32'h0007_0004, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd4,  32'h0, 32'h0007_0000, 1'b0, 4'd4},  // R4
    {K_EV, 4'd3,  32'h0000_00F0, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd5,  32'h0, 32'h0000_00F0, 1'b0, 4'd7},  // R7
    {K_RD, 4'd9,  32'h0, 32'h0000_0001, 1'b0, 4'd8},  // R8
    {K_WR, 4'd6,  32'h0000_FF0F, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd5,  32'h0, 32'h0000_00F0, 1'b1, 4'd7},  // R7
    {K_EV, 4'd3,  32'h0000_0001, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd9,  32'h0, 32'h0000_0002, 1'b1, 4'd8},  // R8
    {K_RD, 4'd5,  32'h0, 32'h0000_00F1, 1'b1, 4'd7},  // R7
    {K_WR, 4'd9,  32'h0000_0005, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd9,  32'h0, 32'h0000_0002, 1'b1, 4'd8},  // R8
    {K_WR, 4'd9,  32'h0000_0000, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd9,  32'h0, 32'h0000_0000, 1'b1, 4'd8},  // R8
    {K_WR, 4'd5,  32'h0000_FFFF, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd5,  32'h0, 32'h0000_0000, 1'b0, 4'd4},  // R4
    {K_EV, 4'd4,  32'h0000_8000, 32'h0, 1'b0, 4'd0},
    {K_WR, 4'd8,  32'h0000_7FFF, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd7,  32'h0, 32'h0000_8000, 1'b1, 4'd7},  // R7
    {K_RD, 4'd10, 32'h0, 32'h0000_0001, 1'b1, 4'd8},  // R8
    {K_WR, 4'd7,  32'h0000_8000, 32'h0, 1'b0, 4'd0},
    {K_RD, 4'd7,  32'h0, 32'h0000_0000, 1'b0, 4'd9},  // R9
    {K_RD, 4'd11, 32'h0, 32'h0000_0000, 1'b0, 4'd11}, // R11
    {K_RD, 4'd15, 32'h0, 32'h0000_0000, 1'b0, 4'd11}  // R11
  };

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic doPulse(input logic [3:0] src, input logic [31:0] d);
    @(negedge clk);
    case (src)
      4'd0: locEvt = d;
      4'd1: hostEvt = d;
      4'd2: linkEvt = d[2:0];
      4'd3: sbeEvt = d[15:0];
      default: dbeEvt = d[15:0];
    endcase
    @(negedge clk);
    locEvt = '0; hostEvt = '0; linkEvt = '0; sbeEvt = '0; dbeEvt = '0;
  endtask

  task automatic doRead(input logic [3:0] a, input logic [31:0] expD,
                        input logic expI, input int req);
    @(negedge clk);
    regAddr = a;
    #1;
    total++;
    if (regRdata !== expD || irq !== expI) begin
      bad++;
      $display("FAIL R%0d addr=%0d rd=%h exp=%h irq=%b exp=%b",
               req, a, regRdata, expD, irq, expI);
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][74:73])
        K_WR: doWrite(VEC[i][72:69], VEC[i][68:37]);
        K_EV: doPulse(VEC[i][72:69], VEC[i][68:37]);
        default: doRead(VEC[i][72:69], VEC[i][36:5], VEC[i][4], int'(VEC[i][3:0]));
      endcase
    end

    // R10: pulse and clearing write on local bit 31 in the same cycle
    doWrite(4'd1, 32'h8000_0000);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'd0; regWdata = 32'h8000_0000; locEvt = 32'h8000_0000;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; locEvt = '0;
    doRead(4'd0, 32'h8000_0000, 1'b1, 10); // R10
    doWrite(4'd0, 32'h8000_0000);
    doRead(4'd0, 32'h0, 1'b0, 9);          // R9 drops once cleared

    // R8: counter saturates (4-bit counter under this bench)
    @(negedge clk);
    sbeEvt = 16'h0100;
    repeat (20) @(negedge clk);
    sbeEvt = '0;
    doRead(4'd9, 32'h0000_000F, 1'b0, 8);  // R8 saturated at 15 (bit masked, irq low)
    doRead(4'd5, 32'h0000_0100, 1'b0, 7);  // R7 masked bit stays off irq

    // R1: reset in mid-run returns defaults
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doRead(4'd1, 32'h0, 1'b0, 1);          // R1
    doRead(4'd5, 32'h0, 1'b0, 1);          // R1
    doRead(4'd9, 32'h0, 1'b0, 1);          // R1

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule